// File: doc/BRIEF.md
# Windowed Pixel Readout Address Sequencer

This block produces the row and column addresses that read a rectangular window out of a pixel array. Software-facing logic elsewhere holds the window origin, the window extent, a per-axis reverse-direction enable and the pair-skipping enables. The sequencer latches all of them when a frame begins. It then walks the window one pixel per accepted step, column by column, and moves to the next row when a line finishes. Each emitted address comes with a valid strobe. A line-end flag marks the last pixel of a row, and a frame-end flag marks the last pixel of the window.

Sub-sampled readout takes two neighbouring addresses and then jumps over a group. This keeps each 2x2 colour cell of the mosaic intact. Reversed readout runs from one past the window's far edge back down to one past its origin, so the first colour read stays the same as in forward readout. There are two banks of 2x skip enables, and a bank-select input chooses which bank the frame uses. A low-power option lets an address advance happen at most on every second clock.

Top module: `win_scan_seq`

## Requirements
- R1: With reversal off, an axis emits the addresses start, start+1, ... up to start+size-1, where size is at least 1. The column axis runs completely within each row, and the row address changes only after a line finishes.
- R2: With reversal on for an axis, that axis emits start+size down to start+1. The two axes reverse independently of each other.
- R3: With 2x skip active on an axis, only offsets o (counted from the start of the walk) where o mod 4 is 0 or 1 are emitted: two read, two skipped.
- R4: With 4x skip on an axis, only offsets where o mod 8 is 0 or 1 are emitted: two read, six skipped.
- R5: When ctx_sel is 0, the 2x skip enables come from the _a inputs. When ctx_sel is 1, they come from the _b inputs. The 4x enables apply in both cases.
- R6: When 4x and 2x skip are both active on one axis, the axis follows the 4x pattern.
- R7: With low_power set for a frame, pix_valid is never high on two consecutive clock cycles.
- R8: A frame begins on the clock edge at which the block is idle and scan_en is high. All window, reversal, skip, bank-select and low-power inputs are captured at that edge only. Changes to them during the frame do not affect it.
- R9: line_end is high together with pix_valid on the last column of every row. frame_end is high together with pix_valid on the last column of the last row. After frame_end the block goes idle.
- R10: An address is emitted (pix_valid high) only in a cycle where pix_en is high. While pix_en is low the addresses hold.
- R11: After reset, and while idle, pix_valid, line_end and frame_end are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Begin a frame when idle |
| pix_en | input | 1 | Pixel step enable |
| low_power | input | 1 | Halve the maximum step rate |
| ctx_sel | input | 1 | Selects the 2x skip bank (0 = a, 1 = b) |
| row_start | input | ADDR_W | First row of the window |
| row_size | input | ADDR_W | Number of rows in the window |
| col_start | input | ADDR_W | First column of the window |
| col_size | input | ADDR_W | Number of columns in the window |
| row_mirror | input | 1 | Reverse the row direction |
| col_mirror | input | 1 | Reverse the column direction |
| row_skip4 | input | 1 | Row 4x pair skip |
| col_skip4 | input | 1 | Column 4x pair skip |
| row_skip2_a | input | 1 | Row 2x pair skip, bank a |
| col_skip2_a | input | 1 | Column 2x pair skip, bank a |
| row_skip2_b | input | 1 | Row 2x pair skip, bank b |
| col_skip2_b | input | 1 | Column 2x pair skip, bank b |
| row_addr | output | ADDR_W | Current row address |
| col_addr | output | ADDR_W | Current column address |
| pix_valid | output | 1 | Address pair is emitted this cycle |
| line_end | output | 1 | Last column of a row |
| frame_end | output | 1 | Last pixel of the frame |

## Verification
The hardest case to reach is a configuration change that arrives after a frame has been captured. From the outputs, such a change can only be seen by comparing addresses that were emitted after it. The bench changes the origin, the reversal, the skip and the low-power inputs a few cycles into a frame. It keeps scoring that frame against the sequence it predicted from the values captured at frame start. Irregular pix_en gaps and low-power frames with reversal and skipping are added, so that the held addresses and the every-other-cycle pacing are seen in combination with the pair jumps.

// File: rtl/win_scan_pkg.sv
package win_scan_pkg;

    typedef enum logic [1:0] {
        SKIP_NONE  = 2'd0,
        SKIP_PAIR2 = 2'd1,
        SKIP_PAIR4 = 2'd2
    } skip_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } scan_state_e;

    typedef struct packed {
        logic       mirror;
        skip_mode_e skip;
    } axis_mode_t;

    typedef struct packed {
        axis_mode_t row;
        axis_mode_t col;
        logic       low_power;
    } frame_mode_t;

    // 4x wins over 2x on the same axis
    function automatic skip_mode_e resolve_skip(input logic s4, input logic s2);
        if (s4)      return SKIP_PAIR4;
        else if (s2) return SKIP_PAIR2;
        else         return SKIP_NONE;
    endfunction

    // distance from the second address of a pair to the first of the next pair
    function automatic logic [3:0] pair_jump(input skip_mode_e m);
        case (m)
            SKIP_PAIR2: return 4'd3;
            SKIP_PAIR4: return 4'd7;
            default:    return 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/scan_axis.sv
module scan_axis
    import win_scan_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              adv,
    input  logic [ADDR_W-1:0] start,
    input  logic [ADDR_W-1:0] size,
    input  axis_mode_t        mode,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int OFF_W = ADDR_W + 1;

    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] off_nxt;
    logic [3:0]       stride;

    always_comb begin
        stride  = off_q[0] ? pair_jump(mode.skip) : 4'd1;
        off_nxt = off_q + {{(OFF_W-4){1'b0}}, stride};
        last    = (off_nxt >= {1'b0, size});
        if (mode.mirror)
            addr = start + size - off_q[ADDR_W-1:0];
        else
            addr = start + off_q[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            off_q <= '0;
        else if (adv)
            off_q <= off_nxt;
    end

endmodule

// File: rtl/scan_pace.sv
module scan_pace (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic running,
    input  logic low_power,
    input  logic pix_en,
    output logic step
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst || load)
            half_q <= 1'b1;
        else if (running && low_power)
            half_q <= ~half_q;
    end

    assign step = running && pix_en && (!low_power || half_q);

endmodule

// File: rtl/win_scan_seq.sv
module win_scan_seq
    import win_scan_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic              pix_en,
    input  logic              low_power,
    input  logic              ctx_sel,
    input  logic [ADDR_W-1:0] row_start,
    input  logic [ADDR_W-1:0] row_size,
    input  logic [ADDR_W-1:0] col_start,
    input  logic [ADDR_W-1:0] col_size,
    input  logic              row_mirror,
    input  logic              col_mirror,
    input  logic              row_skip4,
    input  logic              col_skip4,
    input  logic              row_skip2_a,
    input  logic              col_skip2_a,
    input  logic              row_skip2_b,
    input  logic              col_skip2_b,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic              pix_valid,
    output logic              line_end,
    output logic              frame_end
);
    scan_state_e       state_q;
    frame_mode_t       mode_q;
    frame_mode_t       mode_in;
    logic [ADDR_W-1:0] row_start_q, row_size_q, col_start_q, col_size_q;
    logic              running, load, step, row_last, col_last;

    assign running = (state_q == ST_RUN);
    assign load    = (state_q == ST_IDLE) && scan_en;

    always_comb begin
        mode_in.row.mirror = row_mirror;
        mode_in.col.mirror = col_mirror;
        mode_in.row.skip   = resolve_skip(row_skip4, ctx_sel ? row_skip2_b : row_skip2_a);
        mode_in.col.skip   = resolve_skip(col_skip4, ctx_sel ? col_skip2_b : col_skip2_a);
        mode_in.low_power  = low_power;
    end

    // frame-start capture of every configuration input
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= '0;
            row_start_q <= '0;
            row_size_q  <= '0;
            col_start_q <= '0;
            col_size_q  <= '0;
        end else if (load) begin
            mode_q      <= mode_in;
            row_start_q <= row_start;
            row_size_q  <= row_size;
            col_start_q <= col_start;
            col_size_q  <= col_size;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else if (load)
            state_q <= ST_RUN;
        else if (frame_end)
            state_q <= ST_IDLE;
    end

    scan_pace u_pace (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .running   (running),
        .low_power (mode_q.low_power),
        .pix_en    (pix_en),
        .step      (step)
    );

    scan_axis #(.ADDR_W(ADDR_W)) u_col (
        .clk     (clk),
        .rst     (rst),
        .restart (load || (step && col_last)),
        .adv     (step),
        .start   (col_start_q),
        .size    (col_size_q),
        .mode    (mode_q.col),
        .addr    (col_addr),
        .last    (col_last)
    );

    scan_axis #(.ADDR_W(ADDR_W)) u_row (
        .clk     (clk),
        .rst     (rst),
        .restart (load),
        .adv     (step && col_last),
        .start   (row_start_q),
        .size    (row_size_q),
        .mode    (mode_q.row),
        .addr    (row_addr),
        .last    (row_last)
    );

    assign pix_valid = step;
    assign line_end  = step && col_last;
    assign frame_end = step && col_last && row_last;

endmodule

// File: rtl/win_scan_chk.sv
module win_scan_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              pix_en,
    input logic              pix_valid,
    input logic              line_end,
    input logic              frame_end,
    input logic [ADDR_W-1:0] row_addr,
    input logic              running,
    input logic              lp_cfg
);
    p_quiet_after_reset_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pix_valid && !line_end && !frame_end));

    p_idle_no_valid_r11: assert property (@(posedge clk) disable iff (rst)
        !running |-> !pix_valid);

    p_valid_needs_en_r10: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> pix_en);

    p_lp_spacing_r7: assert property (@(posedge clk) disable iff (rst)
        (lp_cfg && pix_valid) |=> !pix_valid);

    p_frame_end_on_line_end_r9: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> (line_end && pix_valid));

    p_row_held_in_line_r1: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !line_end) |=> $stable(row_addr));

endmodule

bind win_scan_seq win_scan_chk #(.ADDR_W(ADDR_W)) u_win_scan_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_en    (pix_en),
    .pix_valid (pix_valid),
    .line_end  (line_end),
    .frame_end (frame_end),
    .row_addr  (row_addr),
    .running   (running),
    .lp_cfg    (mode_q.low_power)
);

// File: tb/test_win_scan_seq.sv
module test_win_scan_seq;
    localparam int AW    = 11;
    localparam int AMASK = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          scan_en = 0, pix_en = 1, low_power = 0, ctx_sel = 0;
    logic [AW-1:0] row_start = 0, row_size = 0, col_start = 0, col_size = 0;
    logic          row_mirror = 0, col_mirror = 0, row_skip4 = 0, col_skip4 = 0;
    logic          row_skip2_a = 0, col_skip2_a = 0, row_skip2_b = 0, col_skip2_b = 0;
    logic [AW-1:0] row_addr, col_addr;
    logic          pix_valid, line_end, frame_end;

    win_scan_seq #(.ADDR_W(AW)) i_win_scan_seq (
        .clk(clk), .rst(rst), .scan_en(scan_en), .pix_en(pix_en),
        .low_power(low_power), .ctx_sel(ctx_sel),
        .row_start(row_start), .row_size(row_size),
        .col_start(col_start), .col_size(col_size),
        .row_mirror(row_mirror), .col_mirror(col_mirror),
        .row_skip4(row_skip4), .col_skip4(col_skip4),
        .row_skip2_a(row_skip2_a), .col_skip2_a(col_skip2_a),
        .row_skip2_b(row_skip2_b), .col_skip2_b(col_skip2_b),
        .row_addr(row_addr), .col_addr(col_addr),
        .pix_valid(pix_valid), .line_end(line_end), .frame_end(frame_end)
    );

    typedef struct {
        int rs, rz, cs, cz;
        bit mr, mc, r4, c4, r2a, c2a, r2b, c2b, ctx, lp;
    } fcfg_t;

    typedef struct {
        int    row;
        int    col;
        bit    le;
        bit    fe;
        string tag;
    } exp_t;

    exp_t expq[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   lp_watch = 0;
    bit   gap_mode = 0;
    bit   prev_valid = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic int period(input bit s4, input bit s2);
        if (s4) return 8;
        if (s2) return 4;
        return 0;
    endfunction

    // expected sequence computed from the requirements
    task automatic build(input fcfg_t c, input string tag);
        int rl[$];
        int cl[$];
        int rp;
        int cp;
        exp_t e;
        rp = period(c.r4, c.ctx ? c.r2b : c.r2a);
        cp = period(c.c4, c.ctx ? c.c2b : c.c2a);
        for (int o = 0; o < c.rz; o++)
            if (rp == 0 || (o % rp) < 2)
                rl.push_back((c.mr ? (c.rs + c.rz - o) : (c.rs + o)) & AMASK);
        for (int o = 0; o < c.cz; o++)
            if (cp == 0 || (o % cp) < 2)
                cl.push_back((c.mc ? (c.cs + c.cz - o) : (c.cs + o)) & AMASK);
        for (int r = 0; r < rl.size(); r++)
            for (int k = 0; k < cl.size(); k++) begin
                e.row = rl[r];
                e.col = cl[k];
                e.le  = (k == cl.size() - 1);
                e.fe  = e.le && (r == rl.size() - 1);
                e.tag = tag;
                expq.push_back(e);
            end
    endtask

    task automatic apply(input fcfg_t c);
        row_start   = c.rs[AW-1:0];  row_size  = c.rz[AW-1:0];
        col_start   = c.cs[AW-1:0];  col_size  = c.cz[AW-1:0];
        row_mirror  = c.mr;  col_mirror  = c.mc;
        row_skip4   = c.r4;  col_skip4   = c.c4;
        row_skip2_a = c.r2a; col_skip2_a = c.c2a;
        row_skip2_b = c.r2b; col_skip2_b = c.c2b;
        ctx_sel     = c.ctx; low_power   = c.lp;
    endtask

    task automatic run_frame(input fcfg_t c, input string tag,
                             input bit gaps, input int disturb);
        fcfg_t d;
        build(c, tag);
        @(negedge clk);
        apply(c);
        gap_mode = gaps;
        lp_watch = c.lp;
        scan_en  = 1'b1;
        @(negedge clk);
        scan_en  = 1'b0;
        if (disturb > 0) begin
            repeat (disturb) @(negedge clk);
            d     = c;
            d.rs  = c.rs + 3;
            d.cz  = c.cz + 2;
            d.mc  = !c.mc;
            d.mr  = !c.mr;
            d.r4  = 1'b1;
            d.ctx = !c.ctx;
            d.lp  = !c.lp;
            apply(d);
        end
        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(pix_valid == 1'b0, "R9", "idle after frame_end", int'(pix_valid), 0);
        gap_mode = 1'b0;
        lp_watch = 1'b0;
    endtask

    // pix_en driven just after the rising edge, away from the sampling edge
    initial forever begin
        @(posedge clk);
        #2;
        pix_en = gap_mode ? ($urandom_range(0, 3) != 0) : 1'b1;
    end

    // scoreboard monitor
    initial forever begin
        exp_t e;
        @(negedge clk);
        if (!rst) begin
            if (pix_valid) begin
                chk(pix_en == 1'b1, "R10", "valid without pix_en", int'(pix_en), 1);
                if (lp_watch)
                    chk(!prev_valid, "R7", "back-to-back valid in low power", 1, 0);
                if (expq.size() == 0) begin
                    chk(1'b0, "R1", "unexpected pixel row", int'(row_addr), -1);
                end else begin
                    e = expq.pop_front();
                    chk(int'(row_addr) == e.row, e.tag, "row address", int'(row_addr), e.row);
                    chk(int'(col_addr) == e.col, e.tag, "column address", int'(col_addr), e.col);
                    chk(line_end == e.le, "R9", "line_end", int'(line_end), int'(e.le));
                    chk(frame_end == e.fe, "R9", "frame_end", int'(frame_end), int'(e.fe));
                end
            end
            prev_valid = pix_valid;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual no frame completion, expected %0d items drained", expq.size());
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        fcfg_t c;
        repeat (3) @(negedge clk);
        chk(!pix_valid && !line_end && !frame_end, "R11", "flags in reset",
            int'({pix_valid, line_end, frame_end}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!pix_valid, "R11", "valid while idle", int'(pix_valid), 0);

        // R1 plain forward window
        c = '{rs:3, rz:4, cs:5, cz:6, default:0};
        run_frame(c, "R1", 0, 0);

        // R2 both axes reversed, then column only
        c = '{rs:10, rz:3, cs:2, cz:5, mr:1, mc:1, default:0};
        run_frame(c, "R2", 0, 0);
        c = '{rs:0, rz:4, cs:7, cz:4, mc:1, default:0};
        run_frame(c, "R2", 0, 0);

        // R3 bank a 2x skip on both axes
        c = '{rs:8, rz:10, cs:1, cz:9, r2a:1, c2a:1, default:0};
        run_frame(c, "R3", 0, 0);

        // R5 bank b selected: a bits ignored, then b bits used
        c = '{rs:4, rz:6, cs:0, cz:6, r2a:1, c2a:1, ctx:1, default:0};
        run_frame(c, "R5", 0, 0);
        c = '{rs:4, rz:9, cs:0, cz:7, r2b:1, ctx:1, default:0};
        run_frame(c, "R5", 0, 0);

        // R4 4x skip, also reversed
        c = '{rs:8, rz:18, cs:3, cz:17, r4:1, c4:1, default:0};
        run_frame(c, "R4", 0, 0);
        c = '{rs:2, rz:12, cs:5, cz:10, r4:1, c4:1, mr:1, mc:1, default:0};
        run_frame(c, "R4", 0, 0);

        // R6 4x and 2x on the same axis
        c = '{rs:0, rz:17, cs:0, cz:12, r4:1, r2a:1, c4:1, c2a:1, default:0};
        run_frame(c, "R6", 0, 0);

        // R7 low power with skip and reversal
        c = '{rs:6, rz:6, cs:9, cz:8, lp:1, mc:1, c2a:1, default:0};
        run_frame(c, "R7", 0, 0);

        // R10 irregular pix_en
        c = '{rs:1, rz:5, cs:1, cz:7, r2a:1, default:0};
        run_frame(c, "R10", 1, 0);

        // R8 inputs disturbed mid-frame, then a fresh frame
        c = '{rs:20, rz:5, cs:30, cz:6, c2a:1, default:0};
        run_frame(c, "R8", 0, 4);
        c = '{rs:40, rz:3, cs:12, cz:4, lp:1, default:0};
        run_frame(c, "R8", 1, 6);

        // R1 window wrapping past the top of the address range
        c = '{rs:AMASK - 1, rz:3, cs:AMASK, cz:2, default:0};
        run_frame(c, "R1", 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule